// File: doc/BRIEF.md
# Decode-Stage Hazard and Forwarding Unit

This block sits in the decode stage of a five-stage integer pipeline (fetch, decode, execute, memory, write-back). It looks at the source register fields of the instruction now in decode. It compares them with the destination registers held in the decode/execute, execute/memory and memory/write-back pipeline registers. From that comparison it does three things. It builds the operand-select codes that execute applies one cycle later. It delivers the decode-stage operand values, with forwarding applied, for branch comparison and for loading into the decode/execute register. It raises a stall when no forwarding path can supply a value in time.

Branches are decided in decode. The unit compares the two forwarded operands for equal or not-equal. When the branch is taken it returns a redirect and a target program counter to fetch. A redirect is never raised while the stall is active. During a stall the pipeline must hold the program counter and the fetch/decode register, and must load a no-op into decode/execute. The unit is purely combinational and has no clock or reset.

Top module: `hazard_forward_unit`

## Requirements
- R1: When a used source matches a writing, nonzero decode/execute destination, that operand's execute select is 1 (take the execute/memory result). The select encoding is 0 = register-file or decode value, 1 = execute/memory result, 2 = memory/write-back data.
- R2: When a used source matches a writing, nonzero execute/memory destination and does not match decode/execute, the execute select is 2. A match in decode/execute always takes priority over one in execute/memory.
- R3: The decode operand is chosen in this order: the execute/memory ALU result when execute/memory is the youngest matching writer and is not a load; else the memory/write-back data when memory/write-back matches; else the register-file value. If the youngest matching writer is a load in execute/memory, the register-file value passes and memory/write-back is not used.
- R4: Register 0 as a destination never forwards and never stalls.
- R5: Stall is 1 when decode/execute holds a load whose nonzero destination matches a used source.
- R6: Stall is 1 when a branch in decode uses a register written by the instruction in decode/execute.
- R7: Stall is 1 when a branch in decode uses a register that a load in execute/memory is writing. When that writer is not a load, the branch uses the forwarded ALU result instead.
- R8: A branch with the not-equal flag at 0 is taken when its operands are equal, and with the flag at 1 when they differ. The redirect is 1 only for a taken branch that is not stalled. The redirect target always equals the decode program counter plus the offset.
- R9: An operand whose use flag is 0, or a stage whose write enable is 0, produces no forwarding and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_a | input | 5 | First source register of the decode instruction |
| id_rs_b | input | 5 | Second source register of the decode instruction |
| id_use_a | input | 1 | First source is read |
| id_use_b | input | 1 | Second source is read |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_branch_ne | input | 1 | 1 = branch on not-equal, 0 = branch on equal |
| id_pc | input | 32 | Program counter of the decode instruction |
| id_offset | input | 32 | Branch offset |
| rf_data_a | input | 32 | Register-file value for the first source |
| rf_data_b | input | 32 | Register-file value for the second source |
| idex_rd | input | 5 | Destination in decode/execute |
| idex_wr | input | 1 | Decode/execute instruction writes a register |
| idex_load | input | 1 | Decode/execute instruction is a load |
| exmem_rd | input | 5 | Destination in execute/memory |
| exmem_wr | input | 1 | Execute/memory instruction writes a register |
| exmem_load | input | 1 | Execute/memory instruction is a load |
| exmem_alu | input | 32 | ALU result held in execute/memory |
| memwb_rd | input | 5 | Destination in memory/write-back |
| memwb_wr | input | 1 | Memory/write-back instruction writes a register |
| memwb_data | input | 32 | Write-back value held in memory/write-back |
| ex_sel_a | output | 2 | Execute operand select for the first source |
| ex_sel_b | output | 2 | Execute operand select for the second source |
| id_opnd_a | output | 32 | Forwarded decode value, first source |
| id_opnd_b | output | 32 | Forwarded decode value, second source |
| stall | output | 1 | Hold fetch and decode, inject a bubble into execute |
| redirect | output | 1 | Taken branch, fetch loads the target |
| redirect_pc | output | 32 | Branch target |

## Verification
Forwarding and stalling can happen in the same cycle, and so can branch resolution and stalling. One case is a branch whose operand is produced by an ALU instruction in decode/execute. There the execute select shows the forward while the stall must also rise and the taken redirect must be withheld. The bench builds these cases from vectors in which the operands would otherwise make the branch taken, and checks that stall is 1 and redirect is 0. It also checks the matching vectors where the writer has moved one stage on or is not a load: there the stall drops and the redirect appears.

// File: rtl/hazard_pkg.sv
// Shared encodings for the decode-stage hazard unit.
// Assumes: the select code is registered into decode/execute by the pipeline.
package hazard_pkg;
    typedef enum logic [1:0] {
        SEL_DECODE = 2'd0,
        SEL_EXMEM  = 2'd1,
        SEL_MEMWB  = 2'd2
    } opsel_e;
endpackage

// File: rtl/hzd_prio_match.sv
// Two-level priority match of one source against a younger and an older writer.
// Assumes: register 0 is hardwired, so it never matches.
module hzd_prio_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          src_used,
    input  logic [AW-1:0] young_rd,
    input  logic          young_wr,
    input  logic [AW-1:0] old_rd,
    input  logic          old_wr,
    output logic          young_hit,
    output logic          old_hit
);
    logic live;

    // Qualify, then give the younger writer priority.
    always_comb begin
        live      = src_used && (src != '0);
        young_hit = live && young_wr && (young_rd == src);
        old_hit   = live && old_wr && (old_rd == src) && !young_hit;
    end
endmodule

// File: rtl/hzd_stall.sv
// Stall decision from the per-operand match results.
// Assumes: hits are already qualified by use flag, write enable and nonzero register.
module hzd_stall #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0] idex_hit,
    input  logic [NSRC-1:0] exmem_hit,
    input  logic            idex_load,
    input  logic            exmem_load,
    input  logic            is_branch,
    output logic            stall
);
    logic load_use, br_on_ex, br_on_load;

    // Cases where no path delivers the value in time.
    always_comb begin
        load_use   = idex_load && (|idex_hit);
        br_on_ex   = is_branch && (|idex_hit);
        br_on_load = is_branch && exmem_load && (|exmem_hit);
        stall      = load_use || br_on_ex || br_on_load;
    end
endmodule

// File: rtl/hzd_branch.sv
// Decode-stage branch compare and target generation.
// Assumes: the operands already carry any forwarding.
module hzd_branch #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic            is_branch,
    input  logic            on_ne,
    input  logic            stall,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    output logic            redirect,
    output logic [XLEN-1:0] target
);
    logic equal, taken;

    // Resolve direction and hold it back while stalled.
    always_comb begin
        equal    = (opnd_a == opnd_b);
        taken    = on_ne ? !equal : equal;
        redirect = is_branch && taken && !stall;
        target   = pc + offset;
    end
endmodule

// File: rtl/hazard_forward_unit.sv
// Decode-stage hazard detection, forwarding selection and branch resolution.
// Assumes: the register file is read in decode; the caller holds PC and
// fetch/decode and loads a no-op into decode/execute while stall is 1.
module hazard_forward_unit #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [AW-1:0]   id_rs_a,
    input  logic [AW-1:0]   id_rs_b,
    input  logic            id_use_a,
    input  logic            id_use_b,
    input  logic            id_is_branch,
    input  logic            id_branch_ne,
    input  logic [XLEN-1:0] id_pc,
    input  logic [XLEN-1:0] id_offset,
    input  logic [XLEN-1:0] rf_data_a,
    input  logic [XLEN-1:0] rf_data_b,
    input  logic [AW-1:0]   idex_rd,
    input  logic            idex_wr,
    input  logic            idex_load,
    input  logic [AW-1:0]   exmem_rd,
    input  logic            exmem_wr,
    input  logic            exmem_load,
    input  logic [XLEN-1:0] exmem_alu,
    input  logic [AW-1:0]   memwb_rd,
    input  logic            memwb_wr,
    input  logic [XLEN-1:0] memwb_data,
    output logic [1:0]      ex_sel_a,
    output logic [1:0]      ex_sel_b,
    output logic [XLEN-1:0] id_opnd_a,
    output logic [XLEN-1:0] id_opnd_b,
    output logic            stall,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc
);
    import hazard_pkg::*;

    localparam int NSRC = 2;

    logic [AW-1:0]   src    [NSRC];
    logic            used   [NSRC];
    logic [XLEN-1:0] rfval  [NSRC];
    logic [XLEN-1:0] opnd   [NSRC];
    opsel_e          exsel  [NSRC];
    logic [NSRC-1:0] hit_idex, hit_exmem_ex, hit_exmem_id, hit_memwb_id;

    // Gather operand inputs into arrays.
    always_comb begin
        src[0]   = id_rs_a;  src[1]   = id_rs_b;
        used[0]  = id_use_a; used[1]  = id_use_b;
        rfval[0] = rf_data_a; rfval[1] = rf_data_b;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Execute-side view: decode/execute is youngest, execute/memory next.
        hzd_prio_match #(.AW(AW)) u_exm (
            .src(src[g]), .src_used(used[g]),
            .young_rd(idex_rd), .young_wr(idex_wr),
            .old_rd(exmem_rd), .old_wr(exmem_wr),
            .young_hit(hit_idex[g]), .old_hit(hit_exmem_ex[g])
        );
        // Decode-side view: execute/memory is youngest, memory/write-back next.
        hzd_prio_match #(.AW(AW)) u_idm (
            .src(src[g]), .src_used(used[g]),
            .young_rd(exmem_rd), .young_wr(exmem_wr),
            .old_rd(memwb_rd), .old_wr(memwb_wr),
            .young_hit(hit_exmem_id[g]), .old_hit(hit_memwb_id[g])
        );

        // Select code for execute and forwarded value for decode.
        always_comb begin
            if (hit_idex[g])          exsel[g] = SEL_EXMEM;
            else if (hit_exmem_ex[g]) exsel[g] = SEL_MEMWB;
            else                      exsel[g] = SEL_DECODE;

            if (hit_exmem_id[g] && !exmem_load) opnd[g] = exmem_alu;
            else if (hit_memwb_id[g])           opnd[g] = memwb_data;
            else                                opnd[g] = rfval[g];
        end
    end

    hzd_stall #(.NSRC(NSRC)) u_stall (
        .idex_hit(hit_idex), .exmem_hit(hit_exmem_id),
        .idex_load(idex_load), .exmem_load(exmem_load),
        .is_branch(id_is_branch), .stall(stall)
    );

    hzd_branch #(.XLEN(XLEN)) u_branch (
        .opnd_a(opnd[0]), .opnd_b(opnd[1]),
        .is_branch(id_is_branch), .on_ne(id_branch_ne), .stall(stall),
        .pc(id_pc), .offset(id_offset),
        .redirect(redirect), .target(redirect_pc)
    );

    // Drive the output ports.
    always_comb begin
        ex_sel_a  = exsel[0];
        ex_sel_b  = exsel[1];
        id_opnd_a = opnd[0];
        id_opnd_b = opnd[1];
    end
endmodule

// File: rtl/hazard_forward_unit_chk.sv
// Property checker bound to hazard_forward_unit; immediate checks on settled values.
// Assumes: the unit is combinational, so every check holds in every evaluation.
module hazard_forward_unit_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic [AW-1:0] id_rs_a,
    input logic [AW-1:0] id_rs_b,
    input logic          id_use_a,
    input logic          id_use_b,
    input logic          id_is_branch,
    input logic [AW-1:0] idex_rd,
    input logic          idex_wr,
    input logic          idex_load,
    input logic [1:0]    ex_sel_a,
    input logic [1:0]    ex_sel_b,
    input logic          stall,
    input logic          redirect
);
    // Cross-check outputs against the port-level rules.
    always_comb begin
        assert_zero_no_fwd_R4: assert ((ex_sel_a == 2'd0 || id_rs_a != '0) &&
                                       (ex_sel_b == 2'd0 || id_rs_b != '0))
            else $error("register 0 forwarded");
        assert_load_use_stall_R5: assert (!(idex_load && ex_sel_a == 2'd1) || stall)
            else $error("load-use without stall");
        assert_young_priority_R2: assert (!(id_use_a && idex_wr && idex_rd == id_rs_a &&
                                            id_rs_a != '0) || ex_sel_a == 2'd1)
            else $error("older writer chosen over younger");
        assert_no_redirect_in_stall_R8: assert (!(stall && redirect))
            else $error("redirect while stalled");
        assert_unused_quiet_R9: assert (id_use_a || id_use_b || !stall)
            else $error("stall with no source in use");
        assert_branch_stall_R6: assert (!(id_is_branch && ex_sel_b == 2'd1) || stall)
            else $error("branch on execute result not stalled");
    end
endmodule

bind hazard_forward_unit hazard_forward_unit_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .id_rs_a(id_rs_a), .id_rs_b(id_rs_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
    .id_is_branch(id_is_branch), .idex_rd(idex_rd), .idex_wr(idex_wr),
    .idex_load(idex_load), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
    .stall(stall), .redirect(redirect)
);

// File: tb/test_hazard_forward_unit.sv
module test_hazard_forward_unit;
    localparam logic O = 1'b1;
    localparam logic Z = 1'b0;
    localparam logic [31:0] RFA = 32'h0000_000A, RFB = 32'h0000_000B;
    localparam logic [31:0] ALU = 32'h0000_0111, WBD = 32'h0000_0222;
    localparam logic [31:0] PC  = 32'h0000_0100, OFS = 32'h0000_0020;

    typedef struct packed {
        logic [3:0] req;
        logic [4:0] ra, rb;
        logic ua, ub, br, bne;
        logic [4:0] idr; logic idw, idl;
        logic [4:0] emr; logic emw, eml;
        logic [4:0] mwr; logic mww;
        logic [1:0] esa, esb;
        logic est, ered;
        logic [1:0] eopa;   // 0 register file, 1 ALU result, 2 write-back data
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd9,5'd1,5'd2,O,O,Z,Z,5'd3,O,Z,5'd4,O,Z,5'd5,O,2'd0,2'd0,Z,Z,2'd0}, // R9 no match
        '{4'd1,5'd3,5'd2,O,O,Z,Z,5'd3,O,Z,5'd4,O,Z,5'd5,O,2'd1,2'd0,Z,Z,2'd0}, // R1
        '{4'd2,5'd4,5'd2,O,O,Z,Z,5'd3,O,Z,5'd4,O,Z,5'd5,O,2'd2,2'd0,Z,Z,2'd1}, // R2
        '{4'd2,5'd3,5'd2,O,O,Z,Z,5'd3,O,Z,5'd3,O,Z,5'd5,O,2'd1,2'd0,Z,Z,2'd1}, // R2 priority
        '{4'd3,5'd5,5'd2,O,O,Z,Z,5'd3,O,Z,5'd4,O,Z,5'd5,O,2'd0,2'd0,Z,Z,2'd2}, // R3 write-back
        '{4'd3,5'd5,5'd2,O,O,Z,Z,5'd3,O,Z,5'd5,O,Z,5'd5,O,2'd2,2'd0,Z,Z,2'd1}, // R3 priority
        '{4'd3,5'd5,5'd2,O,O,Z,Z,5'd3,O,Z,5'd5,O,O,5'd5,O,2'd2,2'd0,Z,Z,2'd0}, // R3 load young
        '{4'd4,5'd0,5'd0,O,O,O,O,5'd0,O,O,5'd0,O,O,5'd0,O,2'd0,2'd0,Z,O,2'd0}, // R4
        '{4'd5,5'd3,5'd2,O,O,Z,Z,5'd3,O,O,5'd4,O,Z,5'd5,O,2'd1,2'd0,O,Z,2'd0}, // R5 on a
        '{4'd5,5'd1,5'd3,O,O,Z,Z,5'd3,O,O,5'd4,O,Z,5'd5,O,2'd0,2'd1,O,Z,2'd0}, // R5 on b
        '{4'd9,5'd3,5'd3,Z,Z,Z,Z,5'd3,O,O,5'd3,O,Z,5'd3,O,2'd0,2'd0,Z,Z,2'd0}, // R9 unused
        '{4'd9,5'd3,5'd2,O,O,O,O,5'd3,Z,O,5'd3,Z,Z,5'd3,Z,2'd0,2'd0,Z,O,2'd0}, // R9 no write
        '{4'd6,5'd3,5'd2,O,O,O,O,5'd3,O,Z,5'd4,O,Z,5'd5,O,2'd1,2'd0,O,Z,2'd0}, // R6
        '{4'd7,5'd4,5'd2,O,O,O,O,5'd9,O,Z,5'd4,O,O,5'd5,O,2'd2,2'd0,O,Z,2'd0}, // R7 load
        '{4'd7,5'd4,5'd2,O,O,O,O,5'd9,O,Z,5'd4,O,Z,5'd5,O,2'd2,2'd0,Z,O,2'd1}, // R7 ALU
        '{4'd8,5'd7,5'd7,O,O,O,Z,5'd9,O,Z,5'd7,O,Z,5'd5,O,2'd2,2'd2,Z,O,2'd1}, // R8 eq taken
        '{4'd8,5'd1,5'd2,O,O,O,Z,5'd9,O,Z,5'd4,O,Z,5'd5,O,2'd0,2'd0,Z,Z,2'd0}, // R8 eq not
        '{4'd8,5'd7,5'd7,O,O,O,O,5'd9,O,Z,5'd7,O,Z,5'd5,O,2'd2,2'd2,Z,Z,2'd1}  // R8 ne not
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [4:0]  rs_a, rs_b, idr, emr, mwr;
    logic        ua, ub, br, bne, idw, idl, emw, eml, mww;
    logic [31:0] rfa, rfb, exalu, wbd, pc, ofs;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opa, opb, tgt;
    logic        stl, red;
    int checks = 0, errors = 0;

    hazard_forward_unit i_hazard_forward_unit (
        .id_rs_a(rs_a), .id_rs_b(rs_b), .id_use_a(ua), .id_use_b(ub),
        .id_is_branch(br), .id_branch_ne(bne), .id_pc(pc), .id_offset(ofs),
        .rf_data_a(rfa), .rf_data_b(rfb),
        .idex_rd(idr), .idex_wr(idw), .idex_load(idl),
        .exmem_rd(emr), .exmem_wr(emw), .exmem_load(eml), .exmem_alu(exalu),
        .memwb_rd(mwr), .memwb_wr(mww), .memwb_data(wbd),
        .ex_sel_a(sel_a), .ex_sel_b(sel_b), .id_opnd_a(opa), .id_opnd_b(opb),
        .stall(stl), .redirect(red), .redirect_pc(tgt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        rs_a = '0; rs_b = '0; ua = Z; ub = Z; br = Z; bne = Z;
        idr = '0; idw = Z; idl = Z; emr = '0; emw = Z; eml = Z; mwr = '0; mww = Z;
        rfa = RFA; rfb = RFB; exalu = ALU; wbd = WBD; pc = PC; ofs = OFS;
    endtask

    initial begin
        clear_inputs();
        @(negedge clk);
        // Idle state: nothing used, nothing forwarded (R9).
        check("R9 idle stall", {31'd0, stl}, 32'd0);
        check("R9 idle sel_a", {30'd0, sel_a}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            rs_a = VECS[i].ra; rs_b = VECS[i].rb; ua = VECS[i].ua; ub = VECS[i].ub;
            br = VECS[i].br; bne = VECS[i].bne;
            idr = VECS[i].idr; idw = VECS[i].idw; idl = VECS[i].idl;
            emr = VECS[i].emr; emw = VECS[i].emw; eml = VECS[i].eml;
            mwr = VECS[i].mwr; mww = VECS[i].mww;
            @(negedge clk);
            check($sformatf("R%0d v%0d ex_sel_a", VECS[i].req, i), {30'd0, sel_a}, {30'd0, VECS[i].esa});
            check($sformatf("R%0d v%0d ex_sel_b", VECS[i].req, i), {30'd0, sel_b}, {30'd0, VECS[i].esb});
            check($sformatf("R%0d v%0d stall", VECS[i].req, i), {31'd0, stl}, {31'd0, VECS[i].est});
            check($sformatf("R%0d v%0d redirect", VECS[i].req, i), {31'd0, red}, {31'd0, VECS[i].ered});
            check($sformatf("R%0d v%0d opnd_a", VECS[i].req, i), opa,
                  (VECS[i].eopa == 2'd1) ? ALU : (VECS[i].eopa == 2'd2) ? WBD : RFA);
        end

        // R8: target is PC plus offset.
        check("R8 target", tgt, PC + OFS);

        // R3: second operand from write-back data, with the first from the ALU result.
        @(posedge clk);
        clear_inputs();
        rs_a = 5'd6; rs_b = 5'd12; ua = O; ub = O; emr = 5'd6; emw = O; mwr = 5'd12; mww = O;
        @(negedge clk);
        check("R3 opnd_b memwb", opb, WBD);
        check("R3 opnd_a exmem", opa, ALU);

        // R6 with operand b only, taken otherwise.
        @(posedge clk);
        clear_inputs();
        rs_a = 5'd1; rs_b = 5'd8; ua = O; ub = O; br = O; bne = O; idr = 5'd8; idw = O;
        @(negedge clk);
        check("R6 b stall", {31'd0, stl}, 32'd1);
        check("R6 b redirect held", {31'd0, red}, 32'd0);

        // R4: register 0 load in execute/memory with a branch does not stall.
        @(posedge clk);
        clear_inputs();
        br = O; ua = O; ub = O; emr = 5'd0; emw = O; eml = O;
        @(negedge clk);
        check("R4 branch zero load", {31'd0, stl}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule